// File: doc/BRIEF.md
# Hashed Page Table Entry Formatter

This block builds and reads the two 64-bit doublewords of a hashed page table entry. On an encode request it takes a virtual page number, a base page-size index, an actual page-size index, a segment-size code and a physical address. It returns the first doubleword, which holds the abbreviated page number, the segment size and the large-page flag. It also returns the second doubleword, which holds the real page number and the large-page encoding. A decode request reports the actual and base page shifts of an existing entry. Two further requests move an entry between the legacy layout and the newer layout, which keep the segment-size field in different doublewords.

Per-size data is held in four small tables that a plain write port loads: page shifts, abbreviated-page-number masks, large-page encodings and the 256-entry decode table. Every request is accepted on a strobe, and its result appears in output registers one clock later.

Top module: `hpte_codec`

## Requirements
- R1: `out_valid` is high exactly one clock after a clock edge that sees `op_valid` high, and is low otherwise. Reset clears `out_valid`, `out_v`, `out_r`, both shift outputs and `size_bad` to zero.
- R2: A write with `wr_en` high stores data in a table chosen by `wr_sel`. Code 0 stores `wr_data[5:0]` as the shift of size index `wr_addr[3:0]`. Code 1 stores `wr_data` as the number mask of size index `wr_addr[3:0]`. Code 2 stores `wr_data[7:0]` as the large-page encoding at address {base[7:4], actual[3:0]}. Code 3 stores `wr_data[7:0]` as the decode entry for LP value `wr_addr`.
- R3: Encode (`op_code` 0) sets `out_v` to (((vpn >> 11) & ~mask[base]) << 7) OR (seg_size << 62). Bits 6:3 and 1:0 of `out_v` are zero.
- R4: On encode, the large-page flag at bit 2 of `out_v` is set exactly when `act_idx` is not 0. Size index 0 means a 4 KB page.
- R5: On encode with `act_idx` 0, `out_r` is `phys_addr` AND 64'h0FFF_FFFF_FFFF_F000.
- R6: On encode with `act_idx` not 0, `out_r` is `phys_addr` with the low shift[act] bits cleared, ORed with encoding[{base,act}] shifted left by 12.
- R7: Decode (`op_code` 1) with `in_v[2]` clear reports both shifts as 12, with `size_bad` low.
- R8: Decode with `in_v[2]` set uses `in_r[19:12]` to index the decode table. The entry's high nibble is the actual size index and its low nibble is the base size index, and both shifts come from the shift table. A zero entry sets `size_bad` and reports both shifts as 0.
- R9: Legacy-to-new (`op_code` 2) sets `out_v` to `in_v[51:0]` with zeros above. It sets `out_r` to `in_r` with bits 59:58 replaced by `in_v[63:62]`.
- R10: New-to-legacy (`op_code` 3) sets `out_v` to `in_v[51:0]` with `in_r[59:58]` placed at bits 63:62. It sets `out_r` to `in_r` with bits 59:58 cleared.
- R11: A legacy entry whose first-doubleword bits 61:52 and second-doubleword bits 59:58 are zero comes back unchanged from a legacy-to-new conversion followed by a new-to-legacy conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table select: shift, mask, encoding, decode |
| wr_addr | input | 8 | Table address |
| wr_data | input | 64 | Table write data |
| op_valid | input | 1 | Request strobe |
| op_code | input | 2 | 0 encode, 1 decode, 2 legacy-to-new, 3 new-to-legacy |
| vpn | input | 64 | Virtual page number for encode |
| base_idx | input | 4 | Base page-size index |
| act_idx | input | 4 | Actual page-size index |
| seg_size | input | 2 | Segment-size code (0: 256 MB, 1: 1 TB) |
| phys_addr | input | 64 | Physical address for encode |
| in_v | input | 64 | First doubleword for decode or conversion |
| in_r | input | 64 | Second doubleword for decode or conversion |
| out_valid | output | 1 | Result valid |
| out_v | output | 64 | Result first doubleword |
| out_r | output | 64 | Result second doubleword |
| act_shift | output | 6 | Decoded actual page shift |
| base_shift | output | 6 | Decoded base page shift |
| size_bad | output | 1 | Decode hit a zero table entry |

## Verification
The hardest case to reach from the ports is a decode in which the actual and base sizes differ. That result needs a matching program in three tables, and an encoded entry whose LP field lands on the right decode address. The stimulus first loads the shift, mask, encoding and decode tables. It then encodes a large page and feeds the produced second doubleword back in as the decode input, so the path is exercised end to end. An unwritten decode slot is used to reach the invalid-size flag.

// File: rtl/hpte_codec.sv
module hpte_codec #(
  parameter int IDX_W   = 4,
  parameter int LP_W    = 8,
  parameter int SHIFT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [LP_W-1:0]    wr_addr,
  input  logic [63:0]        wr_data,
  input  logic               op_valid,
  input  logic [1:0]         op_code,
  input  logic [63:0]        vpn,
  input  logic [IDX_W-1:0]   base_idx,
  input  logic [IDX_W-1:0]   act_idx,
  input  logic [1:0]         seg_size,
  input  logic [63:0]        phys_addr,
  input  logic [63:0]        in_v,
  input  logic [63:0]        in_r,
  output logic               out_valid,
  output logic [63:0]        out_v,
  output logic [63:0]        out_r,
  output logic [SHIFT_W-1:0] act_shift,
  output logic [SHIFT_W-1:0] base_shift,
  output logic               size_bad
);
  localparam int SIZES    = 1 << IDX_W;
  localparam int LP_DEPTH = 1 << LP_W;
  localparam int ENT_W    = 2 * IDX_W;
  localparam logic [63:0] LOW52  = 64'h000F_FFFF_FFFF_FFFF;
  localparam logic [63:0] RPN4K  = 64'h0FFF_FFFF_FFFF_F000;
  localparam logic [63:0] SEGNEW = 64'h0C00_0000_0000_0000;
  localparam logic [1:0] OP_ENC = 2'd0, OP_DEC = 2'd1, OP_NEW = 2'd2, OP_OLD = 2'd3;

  logic [SHIFT_W-1:0] shift_tbl [SIZES];
  logic [63:0]        mask_tbl  [SIZES];
  logic [LP_W-1:0]    enc_tbl   [LP_DEPTH];
  logic [ENT_W-1:0]   dec_tbl   [LP_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SIZES; i++) begin
        shift_tbl[i] <= '0;
        mask_tbl[i]  <= '0;
      end
      for (int i = 0; i < LP_DEPTH; i++) begin
        enc_tbl[i] <= '0;
        dec_tbl[i] <= '0;
      end
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: shift_tbl[wr_addr[IDX_W-1:0]] <= wr_data[SHIFT_W-1:0];
        2'd1: mask_tbl[wr_addr[IDX_W-1:0]]  <= wr_data;
        2'd2: enc_tbl[wr_addr]              <= wr_data[LP_W-1:0];
        default: dec_tbl[wr_addr]           <= wr_data[ENT_W-1:0];
      endcase
    end
  end

  logic [SHIFT_W-1:0] sh_act;
  logic [63:0]        align_mask;
  logic [LP_W-1:0]    enc_val, lp_field;
  logic [ENT_W-1:0]   dec_ent;
  logic [63:0]        enc_v, enc_r;

  assign sh_act     = shift_tbl[act_idx];
  assign align_mask = (64'd1 << sh_act) - 64'd1;
  assign enc_val    = enc_tbl[{base_idx, act_idx}];
  assign enc_v      = ((((vpn >> 11) & ~mask_tbl[base_idx]) << 7) | ({62'd0, seg_size} << 62))
                      | {61'd0, act_idx != '0, 2'b00};
  assign enc_r      = (act_idx == '0) ? (phys_addr & RPN4K)
                      : ((phys_addr & ~align_mask) | ({{(64-LP_W){1'b0}}, enc_val} << 12));
  assign lp_field   = in_r[12 +: LP_W];
  assign dec_ent    = dec_tbl[lp_field];

  logic [63:0]        nxt_v, nxt_r;
  logic [SHIFT_W-1:0] nxt_as, nxt_bs;
  logic               nxt_bad;

  always_comb begin
    nxt_v = '0; nxt_r = '0; nxt_as = '0; nxt_bs = '0; nxt_bad = 1'b0;
    case (op_code)
      OP_ENC: begin nxt_v = enc_v; nxt_r = enc_r; end
      OP_DEC: begin
        if (!in_v[2]) begin
          nxt_as = SHIFT_W'(12); nxt_bs = SHIFT_W'(12);
        end else if (dec_ent == '0) begin
          nxt_bad = 1'b1;
        end else begin
          nxt_as = shift_tbl[dec_ent[ENT_W-1:IDX_W]];
          nxt_bs = shift_tbl[dec_ent[IDX_W-1:0]];
        end
      end
      OP_NEW: begin
        nxt_v = in_v & LOW52;
        nxt_r = (in_r & ~SEGNEW) | ({62'd0, in_v[63:62]} << 58);
      end
      default: begin
        nxt_v = (in_v & LOW52) | ({62'd0, in_r[59:58]} << 62);
        nxt_r = in_r & ~SEGNEW;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_v <= '0; out_r <= '0;
      act_shift <= '0; base_shift <= '0; size_bad <= 1'b0;
    end else begin
      out_valid <= op_valid;
      if (op_valid) begin
        out_v <= nxt_v; out_r <= nxt_r;
        act_shift <= nxt_as; base_shift <= nxt_bs; size_bad <= nxt_bad;
      end
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == ($past(op_valid) && $past(rst_n)));

  assert_enc_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ENC) |=> (out_v[6:3] == 4'd0 && out_v[1:0] == 2'd0));

  assert_enc_large_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ENC) |=> (out_v[2] == ($past(act_idx) != '0)));

  assert_dec_small_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_DEC && !in_v[2]) |=> (act_shift == SHIFT_W'(12) && !size_bad));

  assert_to_new_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_NEW) |=> (out_v[63:52] == 12'd0 && out_r[59:58] == $past(in_v[63:62])));

  assert_to_old_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_OLD) |=> (out_r[59:58] == 2'd0 && out_v[63:62] == $past(in_r[59:58])));
endmodule

// File: tb/hpte_codec_test.sv
module hpte_codec_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [1:0] wr_sel = 0; logic [7:0] wr_addr = 0; logic [63:0] wr_data = 0;
  logic op_valid = 0; logic [1:0] op_code = 0;
  logic [63:0] vpn = 0, phys_addr = 0, in_v = 0, in_r = 0;
  logic [3:0] base_idx = 0, act_idx = 0; logic [1:0] seg_size = 0;
  logic out_valid, size_bad; logic [63:0] out_v, out_r; logic [5:0] act_shift, base_shift;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpte_codec uut (.clk, .rst_n, .wr_en, .wr_sel, .wr_addr, .wr_data, .op_valid, .op_code,
    .vpn, .base_idx, .act_idx, .seg_size, .phys_addr, .in_v, .in_r,
    .out_valid, .out_v, .out_r, .act_shift, .base_shift, .size_bad);

  typedef struct packed { logic [1:0] op; logic [63:0] v, r, ev, er; } vec_t;
  localparam vec_t CONV [4] = '{
    '{2'd2, 64'h4000_0000_0000_1235, 64'h8000_0000_0012_3196, 64'h0000_0000_0000_1235, 64'h8400_0000_0012_3196},
    '{2'd3, 64'h0001_2345_6789_ABCD, 64'h0C00_0000_0000_0003, 64'hC001_2345_6789_ABCD, 64'h0000_0000_0000_0003},
    '{2'd2, 64'h3FF0_0000_0000_0081, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0081, 64'hF3FF_FFFF_FFFF_FFFF},
    '{2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0400_0000_0000_0180, 64'h400F_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0180}};

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] a, logic [63:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic run(logic [1:0] op);
    @(negedge clk); op_valid = 1; op_code = op;
    @(negedge clk); op_valid = 0;
    check("R1 valid", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic enc(logic [63:0] n, logic [3:0] b, logic [3:0] a, logic [1:0] s, logic [63:0] p);
    vpn = n; base_idx = b; act_idx = a; seg_size = s; phys_addr = p; run(2'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset v", out_v, 64'd0);
    rst_n = 1;

    foreach (CONV[i]) begin
      in_v = CONV[i].v; in_r = CONV[i].r; run(CONV[i].op);
      check(CONV[i].op == 2'd2 ? "R9 v" : "R10 v", out_v, CONV[i].ev);
      check(CONV[i].op == 2'd2 ? "R9 r" : "R10 r", out_r, CONV[i].er);
    end
    @(negedge clk);
    check("R1 idle valid", {63'd0, out_valid}, 64'd0);

    // R2 table programming
    wr(2'd0, 8'h00, 64'd12); wr(2'd0, 8'h01, 64'd16); wr(2'd0, 8'h02, 64'd24);
    wr(2'd1, 8'h01, 64'h1F); wr(2'd1, 8'h02, 64'h1FFF);
    wr(2'd2, 8'h11, 64'h01); wr(2'd2, 8'h02, 64'h38);
    wr(2'd3, 8'h01, 64'h11); wr(2'd3, 8'h38, 64'h20);

    enc(64'h0000_0000_0010_07FF, 4'd0, 4'd0, 2'd0, 64'hF123_4567_89AB_CDEF);
    check("R3 R4 4K v", out_v, 64'h0000_0000_0001_0000);
    check("R5 4K r", out_r, 64'h0123_4567_89AB_C000);

    enc(64'h0000_0000_0001_F800, 4'd1, 4'd1, 2'd1, 64'h0000_0000_1234_5678);
    check("R3 R4 masked v", out_v, 64'h4000_0000_0000_1004);
    check("R6 R2 64K r", out_r, 64'h0000_0000_1234_1000);

    enc(64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 4'd2, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R3 R4 mixed v", out_v, 64'h0FFF_FFFF_FFFF_FF84);
    check("R6 mixed r", out_r, 64'hFFFF_FFFF_FF03_8000);

    in_v = 64'h0; in_r = 64'hFFFF_FFFF_FFFF_FFFF; run(2'd1);
    check("R7 small", {51'd0, size_bad, act_shift, base_shift}, {51'd0, 1'b0, 6'd12, 6'd12});

    in_v = 64'h4; in_r = 64'h0000_0000_0000_1000; run(2'd1);
    check("R8 64K", {51'd0, size_bad, act_shift, base_shift}, {51'd0, 1'b0, 6'd16, 6'd16});

    in_v = 64'h4; in_r = 64'hFFFF_FFFF_FF03_8000; run(2'd1);
    check("R8 mixed", {51'd0, size_bad, act_shift, base_shift}, {51'd0, 1'b0, 6'd24, 6'd12});

    in_v = 64'h4; in_r = 64'h0; run(2'd1);
    check("R8 bad", {51'd0, size_bad, act_shift, base_shift}, {51'd0, 1'b1, 6'd0, 6'd0});

    in_v = 64'h4000_0567_89AB_CDEF; in_r = 64'h8000_0000_0000_01F3; run(2'd2);
    in_v = out_v; in_r = out_r; run(2'd3);
    check("R11 round v", out_v, 64'h4000_0567_89AB_CDEF);
    check("R11 round r", out_r, 64'h8000_0000_0000_01F3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule